// File: doc/BRIEF.md
# Byte Step Unit with Clearable Result Latch

This block adds or subtracts a single carry to one byte at a time. A 16-bit word is updated in two byte passes. The low byte goes first with a carry in of 1. The registered carry out of that pass is then fed back as the carry in of the high byte. The arithmetic core is a ripple chain of incrementer cells. Decrement uses the same chain: the operand is complemented on the way in and the sum is complemented on the way out. Because of that, the decrement borrow appears on the same carry wire as the increment carry.

Each pass result goes into an output latch. The latch follows its input on every clock while its hold control is low, and keeps its contents while hold is high. A clear input forces the latch to zero and takes priority over loading. The upper half of the latched byte is always driven. The lower half drives a shared nibble bus, and that drive has its own enable. The surrounding controller sequences the passes: it marks each valid pass and says whether it is the high byte. When the high pass is accepted, the block writes the complete word to its result register and raises a one-cycle completion pulse.

Top module: `byte_stepper`

## Requirements
- R1: With `dec` = 0, hold low and clear low, `byte_out` one clock later equals (`byte_in` + `cin`) mod 256.
- R2: `carry_out` one clock after a load is `cin` AND (`byte_in` = 0xFF) in increment mode, and `cin` AND (`byte_in` = 0x00) in decrement mode.
- R3: With `dec` = 1, hold low and clear low, `byte_out` one clock later equals (`byte_in` − `cin`) mod 256.
- R4: A valid pass with `pass_hi` = 0 records its result as the low byte. It does not change `word_out` and it does not raise `done`. A valid pass with `pass_hi` = 1 sets `word_out` to {this result, recorded low byte} on the next clock, and `done` is high for exactly that one cycle.
- R5: While `hold` is high and `clr` is low, `byte_out` and `carry_out` keep their values whatever `byte_in`, `cin` and `dec` are.
- R6: When `clr` is high, `byte_out` and `carry_out` are 0 one clock later, whatever the data inputs and `hold` are.
- R7: `nib_oe` follows `nib_en`. When it is high, `nib_bus` carries `byte_out[3:0]`; when it is low, `nib_bus` is 0. `byte_out[7:4]` is unaffected by `nib_en`.
- R8: After reset, `byte_out`, `carry_out`, `word_out` and `done` are all 0.
- R9: With `cin` = 0, the loaded byte equals `byte_in` and `carry_out` is 0 in both modes. This is the second pass of a double-inversion decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | 8 | Operand byte |
| cin | input | 1 | Carry into bit 0 |
| dec | input | 1 | 1 selects decrement, 0 selects increment |
| hold | input | 1 | Latch keeps its value while high |
| clr | input | 1 | Forces the latch to zero; overrides hold |
| pass_vld | input | 1 | The current operand is a word pass |
| pass_hi | input | 1 | The pass is the high byte |
| nib_en | input | 1 | Enables the low-nibble bus drive |
| byte_out | output | 8 | Latched result byte |
| carry_out | output | 1 | Latched carry/borrow out of bit 7 |
| nib_bus | output | 4 | Low-nibble bus drive |
| nib_oe | output | 1 | Nibble bus drive is active |
| word_out | output | 16 | Completed 16-bit result |
| done | output | 1 | One-cycle pulse after the high pass |

## Verification
Two functions can land on the same clock edge: a clear and a load with all-ones data and carry in set. If both took effect, the latch would take 0x00 with carry 1. The bench drives both in the same cycle and expects byte 0x00 with carry 0, which shows the clear won. A word pass can also share an edge with a held latch. The bench does not test that combination. Instead, word results from table vectors are compared against x+1 and x−1 modulo 65536, including the boundary operands 0xFFFF, 0x0000 and 0x00FF.

// File: rtl/step_pkg.sv
package step_pkg;
   typedef enum logic {
      STEP_INC = 1'b0,
      STEP_DEC = 1'b1
   } step_mode_e;

   typedef struct packed {
      logic vld;
      logic hi;
   } pass_ctl_t;
endpackage

// File: rtl/step_ripple.sv
// Ripple incrementer. ALT_POL = 1 stores the carry inverted on every other
// node, so the chain alternates NAND and NOR stages and needs no separate inverters.
module step_ripple #(
   parameter int W       = 8,
   parameter bit ALT_POL = 1'b1
) (
   input  logic [W-1:0] opnd,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (ALT_POL) begin : g_alt
         logic [W:0] node;
         assign node[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            if ((i % 2) == 0) begin : g_even
               // node[i] holds the true carry
               assign node[i+1] = ~(node[i] & opnd[i]);
               assign sum[i]    = opnd[i] ^ node[i];
            end else begin : g_odd
               // node[i] holds the inverted carry
               assign node[i+1] = ~(node[i] | ~opnd[i]);
               assign sum[i]    = opnd[i] ^ ~node[i];
            end
         end
         if ((W % 2) == 0) begin : g_true_out
            assign cout = node[W];
         end else begin : g_inv_out
            assign cout = ~node[W];
         end
      end else begin : g_plain
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign cy[i+1] = cy[i] & opnd[i];
            assign sum[i]  = opnd[i] ^ cy[i];
         end
         assign cout = cy[W];
      end
   endgenerate
endmodule

// File: rtl/step_core.sv
// Increment, or decrement by complementing the operand and the sum.
module step_core
   import step_pkg::*;
#(
   parameter int W       = 8,
   parameter bit ALT_POL = 1'b1
) (
   input  logic [W-1:0] byte_in,
   input  logic         cin,
   input  step_mode_e   mode,
   output logic [W-1:0] res,
   output logic         cout
);
   logic [W-1:0] opnd;
   logic [W-1:0] raw;
   logic         inv;

   assign inv  = (mode == STEP_DEC);
   assign opnd = byte_in ^ {W{inv}};

   step_ripple #(.W(W), .ALT_POL(ALT_POL)) i_ripple (
      .opnd (opnd),
      .cin  (cin),
      .sum  (raw),
      .cout (cout)
   );

   assign res = raw ^ {W{inv}};
endmodule

// File: rtl/step_latch.sv
// Clearable result latch with an enabled drive onto a shared low-nibble bus.
module step_latch #(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   d,
   input  logic           cy_d,
   input  logic           hold,
   input  logic           clr,
   input  logic           nib_en,
   output logic [W-1:0]   q,
   output logic           cy_q,
   output logic [W/2-1:0] nib_bus,
   output logic           nib_oe
);
   localparam int NW = W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         cy_q <= 1'b0;
      end else if (clr) begin
         q    <= '0;
         cy_q <= 1'b0;
      end else if (!hold) begin
         q    <= d;
         cy_q <= cy_d;
      end
   end

   assign nib_oe  = nib_en;
   assign nib_bus = nib_en ? q[NW-1:0] : '0;
endmodule

// File: rtl/step_word.sv
// Stores the low-pass byte and writes the full word when the high pass is accepted.
module step_word
   import step_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  pass_ctl_t    pass,
   input  logic [W-1:0] res,
   output logic [2*W-1:0] word,
   output logic         done
);
   logic [W-1:0] lo_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_pend <= '0;
         word    <= '0;
         done    <= 1'b0;
      end else begin
         done <= pass.vld & pass.hi;
         if (pass.vld && !pass.hi) lo_pend <= res;
         if (pass.vld && pass.hi)  word    <= {res, lo_pend};
      end
   end
endmodule

// File: rtl/byte_stepper.sv
module byte_stepper
   import step_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter bit ALT_POL = 1'b1,
   localparam int NIB_W  = BYTE_W / 2,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              cin,
   input  logic              dec,
   input  logic              hold,
   input  logic              clr,
   input  logic              pass_vld,
   input  logic              pass_hi,
   input  logic              nib_en,
   output logic [BYTE_W-1:0] byte_out,
   output logic              carry_out,
   output logic [NIB_W-1:0]  nib_bus,
   output logic              nib_oe,
   output logic [WORD_W-1:0] word_out,
   output logic              done
);
   generate
      if (BYTE_W < 2 || (BYTE_W % 2) != 0) begin : g_bad_width
         $error("byte_stepper: BYTE_W must be even and at least 2");
      end
   endgenerate

   step_mode_e        mode;
   logic [BYTE_W-1:0] res;
   logic              cout;
   pass_ctl_t         pass;

   assign mode     = dec ? STEP_DEC : STEP_INC;
   assign pass.vld = pass_vld;
   assign pass.hi  = pass_hi;

   step_core #(.W(BYTE_W), .ALT_POL(ALT_POL)) i_core (
      .byte_in (byte_in),
      .cin     (cin),
      .mode    (mode),
      .res     (res),
      .cout    (cout)
   );

   step_latch #(.W(BYTE_W)) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       (res),
      .cy_d    (cout),
      .hold    (hold),
      .clr     (clr),
      .nib_en  (nib_en),
      .q       (byte_out),
      .cy_q    (carry_out),
      .nib_bus (nib_bus),
      .nib_oe  (nib_oe)
   );

   step_word #(.W(BYTE_W)) i_word (
      .clk   (clk),
      .rst_n (rst_n),
      .pass  (pass),
      .res   (res),
      .word  (word_out),
      .done  (done)
   );
endmodule

// File: rtl/byte_stepper_chk.sv
module byte_stepper_chk #(
   parameter int BYTE_W = 8,
   localparam int NIB_W  = BYTE_W / 2,
   localparam int WORD_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] byte_in,
   input logic              cin,
   input logic              dec,
   input logic              hold,
   input logic              clr,
   input logic              pass_vld,
   input logic              pass_hi,
   input logic [BYTE_W-1:0] byte_out,
   input logic              carry_out,
   input logic [NIB_W-1:0]  nib_bus,
   input logic              nib_oe,
   input logic [WORD_W-1:0] word_out,
   input logic              done
);
   AST_INC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && !dec) |=> byte_out == BYTE_W'($past(byte_in) + BYTE_W'($past(cin)))); // R1
   AST_DEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hold && dec) |=> byte_out == BYTE_W'($past(byte_in) - BYTE_W'($past(cin)))); // R3
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> ($stable(byte_out) && $stable(carry_out))); // R5
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (byte_out == '0 && !carry_out)); // R6
   AST_DONE_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(pass_vld && pass_hi)); // R4
   AST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(word_out)); // R4
   AST_NIB_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      nib_oe |-> nib_bus == byte_out[NIB_W-1:0]); // R7
endmodule

bind byte_stepper byte_stepper_chk #(.BYTE_W(BYTE_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .byte_in   (byte_in),
   .cin       (cin),
   .dec       (dec),
   .hold      (hold),
   .clr       (clr),
   .pass_vld  (pass_vld),
   .pass_hi   (pass_hi),
   .byte_out  (byte_out),
   .carry_out (carry_out),
   .nib_bus   (nib_bus),
   .nib_oe    (nib_oe),
   .word_out  (word_out),
   .done      (done)
);

// File: tb/test_byte_stepper.sv
`timescale 1ns/1ps
module test_byte_stepper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  byte_in = '0;
   logic        cin = 1'b0;
   logic        dec = 1'b0;
   logic        hold = 1'b0;
   logic        clr = 1'b0;
   logic        pass_vld = 1'b0;
   logic        pass_hi = 1'b0;
   logic        nib_en = 1'b0;
   logic [7:0]  byte_out;
   logic        carry_out;
   logic [3:0]  nib_bus;
   logic        nib_oe;
   logic [15:0] word_out;
   logic        done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   byte_stepper i_byte_stepper (
      .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .cin(cin), .dec(dec),
      .hold(hold), .clr(clr), .pass_vld(pass_vld), .pass_hi(pass_hi),
      .nib_en(nib_en), .byte_out(byte_out), .carry_out(carry_out),
      .nib_bus(nib_bus), .nib_oe(nib_oe), .word_out(word_out), .done(done)
   );

   // {dec, operand, expected}
   localparam logic [32:0] VEC [9] = '{
      {1'b0, 16'h0000, 16'h0001},
      {1'b0, 16'h00FF, 16'h0100},
      {1'b0, 16'hFFFF, 16'h0000},
      {1'b0, 16'h1234, 16'h1235},
      {1'b0, 16'h7FFF, 16'h8000},
      {1'b1, 16'h0000, 16'hFFFF},
      {1'b1, 16'h0100, 16'h00FF},
      {1'b1, 16'h00FF, 16'h00FE},
      {1'b1, 16'hFFFF, 16'hFFFE}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
   end

   initial begin
      logic [7:0] lo_exp;
      logic       cy_exp;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 byte", byte_out, 8'h00);
      check("R8 carry", carry_out, 1'b0);
      check("R8 word", word_out, 16'h0000);
      check("R8 done", done, 1'b0);
      rst_n = 1'b1;
      tick();

      // Word vectors: two passes with carry chaining (R1 R2 R3 R4)
      for (int k = 0; k < 9; k++) begin
         logic        vd;
         logic [15:0] op;
         logic [15:0] ex;
         {vd, op, ex} = VEC[k];
         dec = vd; byte_in = op[7:0]; cin = 1'b1; pass_vld = 1'b1; pass_hi = 1'b0;
         lo_exp = vd ? op[7:0] - 8'd1 : op[7:0] + 8'd1;
         cy_exp = vd ? (op[7:0] == 8'h00) : (op[7:0] == 8'hFF);
         tick();
         check(vd ? "R3 low byte" : "R1 low byte", byte_out, lo_exp);
         check("R2 low carry", carry_out, cy_exp);
         check("R4 no done after low pass", done, 1'b0);
         byte_in = op[15:8]; cin = carry_out; pass_hi = 1'b1;
         tick();
         pass_vld = 1'b0; pass_hi = 1'b0;
         check("R4 word result", word_out, ex);
         check("R4 done pulse", done, 1'b1);
         tick();
         check("R4 done single cycle", done, 1'b0);
      end

      // R4 lone low pass leaves word unchanged
      dec = 1'b0; byte_in = 8'h10; cin = 1'b1; pass_vld = 1'b1; pass_hi = 1'b0;
      tick();
      pass_vld = 1'b0;
      tick();
      check("R4 word unchanged", word_out, 16'hFFFE);
      check("R4 no done", done, 1'b0);

      // R9 carry in 0 passes data in both modes
      dec = 1'b1; byte_in = 8'hA7; cin = 1'b0;
      tick();
      check("R9 dec passthrough", byte_out, 8'hA7);
      check("R9 dec carry", carry_out, 1'b0);
      dec = 1'b0; byte_in = 8'hFF; cin = 1'b0;
      tick();
      check("R9 inc passthrough", byte_out, 8'hFF);
      check("R9 inc carry", carry_out, 1'b0);

      // R2 carry out set in increment mode
      byte_in = 8'hFF; cin = 1'b1;
      tick();
      check("R2 inc carry", carry_out, 1'b1);
      check("R1 wrap", byte_out, 8'h00);

      // R5 hold keeps value
      byte_in = 8'h5A; cin = 1'b0;
      tick();
      hold = 1'b1; byte_in = 8'h00; cin = 1'b1; dec = 1'b1;
      tick();
      tick();
      check("R5 hold byte", byte_out, 8'h5A);
      check("R5 hold carry", carry_out, 1'b0);

      // R7 nibble drive
      nib_en = 1'b0;
      check("R7 bus off", nib_bus, 4'h0);
      check("R7 oe off", nib_oe, 1'b0);
      check("R7 upper kept", byte_out[7:4], 4'h5);
      nib_en = 1'b1;
      #1;
      check("R7 bus on", nib_bus, 4'hA);
      check("R7 oe on", nib_oe, 1'b1);
      nib_en = 1'b0;

      // R6 clear and full-carry load on one edge: clear wins
      hold = 1'b0; dec = 1'b0; byte_in = 8'hFF; cin = 1'b1; clr = 1'b1;
      tick();
      check("R6 clear byte", byte_out, 8'h00);
      check("R6 clear carry", carry_out, 1'b0);
      // R6 clear also overrides hold
      clr = 1'b0; byte_in = 8'h33; cin = 1'b0;
      tick();
      hold = 1'b1; clr = 1'b1;
      tick();
      check("R6 clear under hold", byte_out, 8'h00);
      clr = 1'b0; hold = 1'b0;
      tick();
      finish_run();
   end
endmodule